// File: doc/BRIEF.md
# Two-Channel Fetch-and-Store DMA Engine

This block moves data on behalf of two independent DMA channels through a single bus-master port. Each channel owns a source pointer, a destination pointer, a transfer count and a control word, all loaded through a simple register-write port. While a channel is running and its request input is high, the engine carries out transfers, one after another. Each transfer is two separate bus cycles: a fetch from the source and then a store to the destination. The fetched value waits in a temporary register between the two cycles.

Either pointer can address memory space or I/O space, so all four space pairings are possible. A transfer is either a byte or a 16-bit word, and it may use an odd or an even address. After every transfer each pointer independently steps up, steps down or holds. The step is 1 for a byte and 2 for a word. A transfer count and an optional stop-on-zero give bounded block moves. When both channels want the bus, a per-channel priority bit picks the winner. Channels of equal priority take turns.

The engine is placed next to a bus arbiter. Its request inputs are assumed to be synchronized already, and how the bus is shared with a processor is handled outside this block.

Top module: `dma2ch_engine`

## Requirements
- R1: After synchronous reset, `bus_req` and `bus_wr` are 0 and both channels are stopped. No bus cycle starts, even with both `dreq` bits high, until the control register of a channel is written with its run bit set.
- R2: After each completed transfer, each pointer moves according to its 2-bit step field: 00 or 11 holds, 01 adds, 10 subtracts. The step is 1 for a byte transfer and 2 for a word transfer. Arithmetic wraps modulo 2^20.
- R3: `bus_io` equals the source-space bit during a fetch and the destination-space bit during a store, where 1 means I/O space and 0 means memory space. All four pairings work.
- R4: Every transfer is a fetch cycle (`bus_wr`=0, address = source pointer) followed directly by a store cycle (`bus_wr`=1, address = destination pointer). The store drives the fetched data on `bus_wdata`.
- R5: With the width bit at 1, `bus_word` is 1 and all 16 data bits are carried. With the width bit at 0, `bus_word` is 0 and the store carries the low fetched byte with the upper byte zero. Odd and even addresses are accepted for both widths.
- R6: Each bus cycle holds `bus_req`, `bus_addr` and `bus_wr` steady for at least three clocks and waits in its third state for `bus_done`. With `bus_done` first seen after w extra clocks, the store request rises exactly 4+w clocks after the fetch request rose. With no extra wait, a transfer takes 8 clocks.
- R7: The 16-bit count decrements after each store. When stop-on-count is set and the count reaches zero, the run bit clears and no further bus cycle starts.
- R8: With stop-on-count clear, the channel keeps transferring after the count passes zero. The count wraps to 0xFFFF.
- R9: When both channels request at equal priority, grants alternate. Channel 0 goes first after reset.
- R10: When both channels request and only one has its priority bit set, that channel is granted every time until it stops requesting.
- R11: Reset during a bus cycle drops `bus_req` at once, abandons the transfer and leaves both channels stopped.
- R12: Register writes use `reg_ch` to pick the channel and `reg_sel` to pick the register: 0 = source pointer, 1 = destination pointer, 2 = count (low 16 bits), 3 = control. The control bits are: 0 run, 1 word width, 2 source in I/O space, 3 destination in I/O space, [5:4] source step, [7:6] destination step, 8 stop on count, 9 high priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dreq | input | 2 | Per-channel transfer request, already synchronized |
| reg_we | input | 1 | Register write strobe |
| reg_ch | input | 1 | Channel selected by the write |
| reg_sel | input | 2 | Register selected by the write |
| reg_wdata | input | 20 | Write data |
| bus_req | output | 1 | Bus cycle request, high through states 1 to 3 |
| bus_addr | output | 20 | Bus cycle address |
| bus_io | output | 1 | 1 = I/O space, 0 = memory space |
| bus_wr | output | 1 | 1 = store, 0 = fetch |
| bus_word | output | 1 | 1 = word, 0 = byte |
| bus_wdata | output | 16 | Store data |
| bus_rdata | input | 16 | Fetch data, sampled together with bus_done |
| bus_done | input | 1 | Bus cycle completion, sampled in state 3 |

## Verification
A wrong pointer step, space bit or width shows up on `bus_addr`, `bus_io` or `bus_word` at the very next fetch or store of that channel. A wrong temporary register shows up on `bus_wdata` in the store that follows the fetch. Count or terminal logic that is wrong shows up only at the end of a block: either an extra bus cycle appears within a few clocks after the expected last store, or the final transfers are missing. A faulty arbiter shows up as a change in the order of source addresses, because the two channels' addresses are kept in separate ranges.

// File: rtl/dma2ch_pkg.sv
package dma2ch_pkg;

  // Control word bit positions; software and the bench both depend on them
  localparam int CTL_RUN     = 0;
  localparam int CTL_WORD    = 1;
  localparam int CTL_SRC_IO  = 2;
  localparam int CTL_DST_IO  = 3;
  localparam int CTL_SRC_STP = 4;
  localparam int CTL_DST_STP = 6;
  localparam int CTL_STOP_TC = 8;
  localparam int CTL_HIPRI   = 9;
  localparam int CTL_W       = 10;

  // Register select codes
  localparam logic [1:0] SEL_SRC = 2'd0;
  localparam logic [1:0] SEL_DST = 2'd1;
  localparam logic [1:0] SEL_CNT = 2'd2;
  localparam logic [1:0] SEL_CTL = 2'd3;

  typedef enum logic [1:0] {
    STEP_HOLD  = 2'b00,
    STEP_UP    = 2'b01,
    STEP_DOWN  = 2'b10,
    STEP_HOLDX = 2'b11
  } step_e;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_T1   = 3'd1,
    SQ_T2   = 3'd2,
    SQ_T3   = 3'd3,
    SQ_T4   = 3'd4
  } sq_e;

endpackage

// File: rtl/dma2ch_channel.sv
module dma2ch_channel
  import dma2ch_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              xfer_done,
  input  logic              dreq,
  output logic [ADDR_W-1:0] src_ptr,
  output logic [ADDR_W-1:0] dst_ptr,
  output logic              want,
  output logic              word,
  output logic              src_io,
  output logic              dst_io,
  output logic              hi_pri
);

  logic [CTL_W-1:0] ctl_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ADDR_W-1:0] src_nx, dst_nx;

  function automatic logic [ADDR_W-1:0] advance(input logic [ADDR_W-1:0] p,
                                                 input step_e m,
                                                 input logic w);
    logic [ADDR_W-1:0] d;
    d = w ? ADDR_W'(2) : ADDR_W'(1);
    case (m)
      STEP_UP:   return p + d;
      STEP_DOWN: return p - d;
      default:   return p;
    endcase
  endfunction

  assign word   = ctl_q[CTL_WORD];
  assign src_io = ctl_q[CTL_SRC_IO];
  assign dst_io = ctl_q[CTL_DST_IO];
  assign hi_pri = ctl_q[CTL_HIPRI];
  assign want   = ctl_q[CTL_RUN] & dreq;

  assign src_nx = advance(src_ptr, step_e'(ctl_q[CTL_SRC_STP +: 2]), ctl_q[CTL_WORD]);
  assign dst_nx = advance(dst_ptr, step_e'(ctl_q[CTL_DST_STP +: 2]), ctl_q[CTL_WORD]);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= '0;
      cnt_q   <= '0;
      src_ptr <= '0;
      dst_ptr <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_SRC: src_ptr <= wr_data;
        SEL_DST: dst_ptr <= wr_data;
        SEL_CNT: cnt_q   <= wr_data[CNT_W-1:0];
        default: ctl_q   <= wr_data[CTL_W-1:0];
      endcase
    end else if (xfer_done) begin
      src_ptr <= src_nx;
      dst_ptr <= dst_nx;
      cnt_q   <= cnt_q - CNT_W'(1);
      if (ctl_q[CTL_STOP_TC] && cnt_q == CNT_W'(1))
        ctl_q[CTL_RUN] <= 1'b0;
    end
  end

endmodule

// File: rtl/dma2ch_arbiter.sv
module dma2ch_arbiter (
  input  logic clk,
  input  logic rst,
  input  logic want0,
  input  logic want1,
  input  logic pri0,
  input  logic pri1,
  input  logic take,
  output logic gnt_valid,
  output logic gnt_ch
);

  logic last_q;

  always_comb begin
    gnt_valid = want0 | want1;
    if (want0 && want1) begin
      if (pri0 != pri1) gnt_ch = pri1;
      else              gnt_ch = ~last_q;
    end else begin
      gnt_ch = want1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       last_q <= 1'b1;
    else if (take) last_q <= gnt_ch;
  end

endmodule

// File: rtl/dma2ch_sequencer.sv
module dma2ch_sequencer
  import dma2ch_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gnt_valid,
  input  logic              gnt_ch,
  input  logic [ADDR_W-1:0] sel_src,
  input  logic [ADDR_W-1:0] sel_dst,
  input  logic              sel_src_io,
  input  logic              sel_dst_io,
  input  logic              sel_word,
  output logic              take,
  output logic              upd,
  output logic              act_ch,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_io,
  output logic              bus_wr,
  output logic              bus_word,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_done
);

  localparam int HALF = DATA_W / 2;

  sq_e               state_q;
  logic              store_q;
  logic [ADDR_W-1:0] dst_q;
  logic              dst_io_q;
  logic [DATA_W-1:0] tmp_q;

  assign take = (state_q == SQ_IDLE) && gnt_valid;
  assign upd  = (state_q == SQ_T4) && store_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SQ_IDLE;
      store_q   <= 1'b0;
      act_ch    <= 1'b0;
      bus_req   <= 1'b0;
      bus_addr  <= '0;
      bus_io    <= 1'b0;
      bus_wr    <= 1'b0;
      bus_word  <= 1'b0;
      bus_wdata <= '0;
      dst_q     <= '0;
      dst_io_q  <= 1'b0;
      tmp_q     <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: if (gnt_valid) begin
          state_q   <= SQ_T1;
          store_q   <= 1'b0;
          act_ch    <= gnt_ch;
          bus_req   <= 1'b1;
          bus_addr  <= sel_src;
          bus_io    <= sel_src_io;
          bus_wr    <= 1'b0;
          bus_word  <= sel_word;
          bus_wdata <= '0;
          dst_q     <= sel_dst;
          dst_io_q  <= sel_dst_io;
        end
        SQ_T1: state_q <= SQ_T2;
        SQ_T2: state_q <= SQ_T3;
        SQ_T3: if (bus_done) begin
          state_q <= SQ_T4;
          bus_req <= 1'b0;
          if (!store_q)
            tmp_q <= bus_word ? bus_rdata
                              : {{(DATA_W-HALF){1'b0}}, bus_rdata[HALF-1:0]};
        end
        SQ_T4: begin
          if (!store_q) begin
            state_q   <= SQ_T1;
            store_q   <= 1'b1;
            bus_req   <= 1'b1;
            bus_addr  <= dst_q;
            bus_io    <= dst_io_q;
            bus_wr    <= 1'b1;
            bus_wdata <= tmp_q;
          end else begin
            state_q <= SQ_IDLE;
            bus_wr  <= 1'b0;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma2ch_engine.sv
module dma2ch_engine
  import dma2ch_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        dreq,
  input  logic              reg_we,
  input  logic              reg_ch,
  input  logic [1:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_io,
  output logic              bus_wr,
  output logic              bus_word,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_done
);

  localparam int NCH = 2;

  logic [ADDR_W-1:0] src_a [NCH];
  logic [ADDR_W-1:0] dst_a [NCH];
  logic [NCH-1:0]    want_a, word_a, sio_a, dio_a, pri_a;
  logic              gnt_valid, gnt_ch, take, upd, act_ch;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dma2ch_channel #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (reg_we && (reg_ch == 1'(i))),
      .wr_sel   (reg_sel),
      .wr_data  (reg_wdata),
      .xfer_done(upd && (act_ch == 1'(i))),
      .dreq     (dreq[i]),
      .src_ptr  (src_a[i]),
      .dst_ptr  (dst_a[i]),
      .want     (want_a[i]),
      .word     (word_a[i]),
      .src_io   (sio_a[i]),
      .dst_io   (dio_a[i]),
      .hi_pri   (pri_a[i])
    );
  end

  dma2ch_arbiter u_arb (
    .clk      (clk),
    .rst      (rst),
    .want0    (want_a[0]),
    .want1    (want_a[1]),
    .pri0     (pri_a[0]),
    .pri1     (pri_a[1]),
    .take     (take),
    .gnt_valid(gnt_valid),
    .gnt_ch   (gnt_ch)
  );

  dma2ch_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .gnt_valid (gnt_valid),
    .gnt_ch    (gnt_ch),
    .sel_src   (src_a[gnt_ch]),
    .sel_dst   (dst_a[gnt_ch]),
    .sel_src_io(sio_a[gnt_ch]),
    .sel_dst_io(dio_a[gnt_ch]),
    .sel_word  (word_a[gnt_ch]),
    .take      (take),
    .upd       (upd),
    .act_ch    (act_ch),
    .bus_req   (bus_req),
    .bus_addr  (bus_addr),
    .bus_io    (bus_io),
    .bus_wr    (bus_wr),
    .bus_word  (bus_word),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_done  (bus_done)
  );

endmodule

// File: rtl/dma2ch_checker.sv
module dma2ch_checker #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr
);

  // R1 / R11: one cycle after a reset edge no bus cycle is requested
  assert_idle_after_reset_R11: assert property (@(posedge clk)
    $past(rst) |-> !bus_req);

  // R6: address and direction stay steady while a request is held
  assert_steady_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_req && $past(bus_req)) |-> ($stable(bus_addr) && $stable(bus_wr)));

  // R6: a request, once raised, lasts at least three clocks
  assert_min_request_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |=> bus_req ##1 bus_req);

  // R4: the end of a fetch is followed at once by a store
  assert_store_follows_fetch_R4: assert property (@(posedge clk) disable iff (rst)
    ($fell(bus_req) && !bus_wr) |=> (bus_req && bus_wr));

  // R4: a store request never rises straight out of idle
  assert_no_lone_store_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_req) && bus_wr) |-> !$past(bus_wr, 2));

endmodule

bind dma2ch_engine dma2ch_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .bus_req (bus_req),
  .bus_wr  (bus_wr),
  .bus_addr(bus_addr)
);

// File: tb/dma2ch_engine_tb.sv
module dma2ch_engine_tb_top;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [19:0] addr;
    logic        io;
    logic        wr;
    logic        word;
    logic [15:0] data;
  } bc_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  dreq = 2'b00;
  logic        reg_we = 1'b0;
  logic        reg_ch = 1'b0;
  logic [1:0]  reg_sel = 2'b00;
  logic [19:0] reg_wdata = '0;
  logic        bus_req, bus_io, bus_wr, bus_word;
  logic [19:0] bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata = '0;
  logic        bus_done = 1'b0;

  dma2ch_engine dut_i (
    .clk(clk), .rst(rst), .dreq(dreq), .reg_we(reg_we), .reg_ch(reg_ch),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .bus_req(bus_req),
    .bus_addr(bus_addr), .bus_io(bus_io), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_done(bus_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  bc_t exp_q[$];
  int cyc = 0, reqcnt = 0, wait_now = 0, fetch_wait = 0, fetch_rise = 0;
  int bus_cycles = 0, stores = 0, max_wait = 2;
  bit done_given = 0;

  function automatic void chk(string tag, logic [39:0] act, logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endfunction

  function automatic logic [15:0] data_of(logic [19:0] a, logic io);
    return a[15:0] ^ {a[19:16], 12'h000} ^ (io ? 16'h5a5a : 16'h3c3c);
  endfunction

  function automatic logic [19:0] adv(logic [19:0] p, logic [1:0] m, bit w);
    logic [19:0] d;
    d = w ? 20'd2 : 20'd1;
    if (m == 2'b01) return p + d;
    if (m == 2'b10) return p - d;
    return p;
  endfunction

  function automatic logic [19:0] mkctl(bit run, bit word, bit sio, bit dio,
                                        logic [1:0] sm, logic [1:0] dm, bit tc, bit hp);
    return {10'b0, hp, tc, dm, sm, dio, sio, word, run};
  endfunction

  // Expected bus cycles for n transfers of one channel (R2 R3 R4 R5)
  task automatic plan(logic [19:0] s, logic [19:0] d, bit word, bit sio, bit dio,
                      logic [1:0] sm, logic [1:0] dm, int n);
    for (int i = 0; i < n; i++) begin
      logic [15:0] v;
      v = data_of(s, sio);
      exp_q.push_back('{addr: s, io: sio, wr: 1'b0, word: word, data: 16'h0});
      exp_q.push_back('{addr: d, io: dio, wr: 1'b1, word: word,
                        data: word ? v : {8'h00, v[7:0]}});
      s = adv(s, sm, word);
      d = adv(d, dm, word);
    end
  endtask

  always @(posedge clk) cyc++;

  // Bus responder and monitor
  always @(negedge clk) begin
    bus_done = 1'b0;
    if (!rst && bus_req) begin
      reqcnt++;
      if (reqcnt == 1) begin
        wait_now = $urandom_range(0, max_wait);
        if (!bus_wr) begin
          fetch_rise = cyc;
          fetch_wait = wait_now;
        end else begin
          chk("R6 fetch-to-store spacing", 40'(cyc - fetch_rise), 40'(4 + fetch_wait));
        end
      end
      if (!done_given && reqcnt == 3 + wait_now) begin
        done_given = 1;
        bus_cycles++;
        bus_done = 1'b1;
        if (!bus_wr) bus_rdata = data_of(bus_addr, bus_io);
        else stores++;
        if (exp_q.size() == 0) begin
          chk("R7 unexpected bus cycle", {bus_wr, bus_addr}, 40'hFFFFFFFFFF);
        end else begin
          bc_t e;
          e = exp_q.pop_front();
          chk("R2 R3 R4 R5 address/space/direction/width",
              {bus_wr, bus_io, bus_word, bus_addr}, {e.wr, e.io, e.word, e.addr});
          if (bus_wr) chk("R4 R5 stored data", bus_wdata, e.data);
        end
      end
    end else begin
      reqcnt = 0;
      done_given = 0;
    end
  end

  task automatic wreg(bit ch, logic [1:0] sel, logic [19:0] v);
    reg_we = 1'b1; reg_ch = ch; reg_sel = sel; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // R12 register layout
  task automatic prog(bit ch, logic [19:0] s, logic [19:0] d, logic [15:0] n, logic [19:0] c);
    wreg(ch, 2'd0, s);
    wreg(ch, 2'd1, d);
    wreg(ch, 2'd2, {4'h0, n});
    wreg(ch, 2'd3, c);
  endtask

  task automatic do_reset();
    rst = 1'b1; dreq = 2'b00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_q.delete();
  endtask

  task automatic drain(string tag);
    int k = 0;
    while ((exp_q.size() != 0 || bus_req) && k < 2000) begin
      @(negedge clk);
      k++;
    end
    chk(tag, 40'(exp_q.size()), 40'd0);
  endtask

  task automatic quiet(string tag);
    int b = bus_cycles;
    repeat (40) @(negedge clk);
    chk(tag, 40'(bus_cycles - b), 40'd0);
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_up();
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'h0000_1ee7);
    @(negedge clk);
    do_reset();
    chk("R1 reset outputs", {bus_req, bus_wr}, 40'd0);
    dreq = 2'b11;
    quiet("R1 no transfer while stopped");
    dreq = 2'b00;

    // R7 R3: memory to I/O, word, source up, destination hold, stop at zero
    max_wait = 0;
    prog(0, 20'h01000, 20'h00300, 16'd3, mkctl(1, 1, 0, 1, 2'b01, 2'b00, 1, 0));
    plan(20'h01000, 20'h00300, 1, 0, 1, 2'b01, 2'b00, 3);
    dreq = 2'b01;
    drain("R7 three word transfers seen");
    quiet("R7 stopped at zero count");
    dreq = 2'b00;

    // R2 R5: I/O to memory, byte, odd, source down across zero
    max_wait = 2;
    prog(1, 20'h00001, 20'h0F0F1, 16'd3, mkctl(1, 0, 1, 0, 2'b10, 2'b01, 1, 0));
    plan(20'h00001, 20'h0F0F1, 0, 1, 0, 2'b10, 2'b01, 3);
    dreq = 2'b10;
    drain("R2 byte decrement wrap");
    quiet("R7 channel 1 stopped");
    dreq = 2'b00;

    // R3: memory to memory and I/O to I/O
    prog(0, 20'h8FFF3, 20'h12345, 16'd2, mkctl(1, 1, 0, 0, 2'b11, 2'b10, 1, 0));
    plan(20'h8FFF3, 20'h12345, 1, 0, 0, 2'b11, 2'b10, 2);
    dreq = 2'b01;
    drain("R3 memory to memory");
    dreq = 2'b00;
    prog(1, 20'h00077, 20'h00088, 16'd2, mkctl(1, 0, 1, 1, 2'b00, 2'b00, 1, 0));
    plan(20'h00077, 20'h00088, 0, 1, 1, 2'b00, 2'b00, 2);
    dreq = 2'b10;
    drain("R3 I/O to I/O");
    dreq = 2'b00;

    // R9: equal priority alternates, channel 0 first after reset
    do_reset();
    prog(0, 20'h10000, 20'h20000, 16'd2, mkctl(1, 1, 0, 0, 2'b01, 2'b01, 1, 0));
    prog(1, 20'h30000, 20'h40000, 16'd2, mkctl(1, 1, 0, 0, 2'b01, 2'b01, 1, 0));
    plan(20'h10000, 20'h20000, 1, 0, 0, 2'b01, 2'b01, 1);
    plan(20'h30000, 20'h40000, 1, 0, 0, 2'b01, 2'b01, 1);
    plan(20'h10002, 20'h20002, 1, 0, 0, 2'b01, 2'b01, 1);
    plan(20'h30002, 20'h40002, 1, 0, 0, 2'b01, 2'b01, 1);
    dreq = 2'b11;
    drain("R9 alternating grant order");
    quiet("R9 both stopped");
    dreq = 2'b00;

    // R10: channel 1 high priority wins until done
    prog(0, 20'h10000, 20'h20000, 16'd2, mkctl(1, 1, 0, 0, 2'b01, 2'b01, 1, 0));
    prog(1, 20'h30000, 20'h40000, 16'd2, mkctl(1, 1, 0, 0, 2'b01, 2'b01, 1, 1));
    plan(20'h30000, 20'h40000, 1, 0, 0, 2'b01, 2'b01, 2);
    plan(20'h10000, 20'h20000, 1, 0, 0, 2'b01, 2'b01, 2);
    dreq = 2'b11;
    drain("R10 priority grant order");
    dreq = 2'b00;

    // R8: stop on count off, count 1 keeps going past zero
    begin
      int base;
      base = stores;
      prog(0, 20'h05000, 20'h06000, 16'd1, mkctl(1, 1, 0, 0, 2'b01, 2'b01, 0, 0));
      plan(20'h05000, 20'h06000, 1, 0, 0, 2'b01, 2'b01, 3);
      dreq = 2'b01;
      while (stores < base + 3) @(negedge clk);
      wreg(0, 2'd3, mkctl(0, 1, 0, 0, 2'b01, 2'b01, 0, 0));
      drain("R8 transfers past zero count");
      chk("R8 store count", 40'(stores - base), 40'd3);
      dreq = 2'b00;
    end

    // R11: reset in the middle of a fetch
    prog(0, 20'h07000, 20'h07100, 16'd5, mkctl(1, 1, 0, 0, 2'b01, 2'b01, 1, 0));
    dreq = 2'b01;
    while (!bus_req) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_q.delete();
    chk("R11 request dropped by reset", {bus_req, bus_wr}, 40'd0);
    quiet("R11 channel stopped after reset");
    dreq = 2'b00;

    // Random configurations (R2 R3 R5 R7)
    for (int it = 0; it < 14; it++) begin
      bit ch, w, si, di;
      logic [1:0] sm, dm;
      logic [19:0] s, d;
      int n;
      ch = 1'($urandom_range(0, 1));
      w  = 1'($urandom_range(0, 1));
      si = 1'($urandom_range(0, 1));
      di = 1'($urandom_range(0, 1));
      sm = 2'($urandom_range(0, 3));
      dm = 2'($urandom_range(0, 3));
      s  = 20'($urandom);
      d  = 20'($urandom);
      n  = $urandom_range(1, 4);
      max_wait = $urandom_range(0, 3);
      prog(ch, s, d, 16'(n), mkctl(1, w, si, di, sm, dm, 1, 0));
      plan(s, d, w, si, di, sm, dm, n);
      dreq = ch ? 2'b10 : 2'b01;
      drain("R2 R3 R5 random block");
      quiet("R7 random block stopped");
      dreq = 2'b00;
    end

    finish_up();
  end

endmodule